// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank synchronous DRAM and walks the memory from power-on to a state where normal traffic may begin. When reset is released it holds the command bus idle, with clock enable and the data masks high, for a start-up pause of a programmable length. It then issues one precharge that covers all banks and loads the mode register with a word built from the burst length, wrap type and CAS latency inputs. It also issues a programmable number of auto-refresh commands. A parameter chooses whether the refresh burst comes before or after the mode-register load.

Every gap after a command is filled with NOP cycles: the precharge recovery, the settle time after the mode load and the refresh cycle time are all parameters given in clocks. When the last required command and its gap are complete, the sequencer raises `done_o` and keeps the bus in NOP with the masks low. The memory controller that follows may then schedule activates. Asserting reset at any point stops the sequence and starts it again from the pause.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_ni` is low the bus shows DESELECT ({cs_n,ras_n,cas_n,we_n} = 1111), `cke_o` and every `dqm_o` bit are high, `ba_o` and `addr_o` are zero and `done_o` is low.
- R2: In the first clock after reset release the bus still shows DESELECT. For the next `PAUSE_CYC` clocks it shows NOP (0111) with `cke_o` and `dqm_o` high, and no other command appears.
- R3: The first command after the pause is a precharge of all banks: code 0010 with `addr_o[10]` high and every other address bit zero.
- R4: After the precharge, exactly `T_RP-1` NOP cycles follow before the next command.
- R5: The mode-register load is code 0000. `ba_o` is zero, `addr_o[2:0]` carries the burst length, `addr_o[3]` the wrap type and `addr_o[6:4]` the CAS latency, and all higher address bits are zero.
- R6: The mode-register load is issued only after the all-bank precharge, and `cke_o` is high in the clock before it.
- R7: Exactly `T_MRD-1` NOP cycles (at least one) follow the mode-register load.
- R8: `N_REF` auto-refresh commands (code 0001) are issued, each followed by `T_RC-1` NOP cycles. With `REF_FIRST`=0 they follow the mode load; with `REF_FIRST`=1 they precede it.
- R9: `done_o` rises only after the mode load and all refreshes, including the gap that follows the last of them. It then stays high, with the bus in NOP and `dqm_o` low.
- R10: Asserting reset part-way through the sequence restarts it from the pause, and the new run uses the current mode inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset; restarts the sequence |
| bl_i | input | 3 | Burst length code for the mode word |
| wrap_i | input | 1 | Wrap type: 0 sequential, 1 interleaved |
| cl_i | input | 3 | CAS latency code for the mode word |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus, carrying the all-bank bit and the mode word |
| cke_o | output | 1 | Clock enable to the memory |
| dqm_o | output | DQM_W | Data masks |
| done_o | output | 1 | Initialization complete |

## Verification
The command pins are decoded directly from the sequencer state, so a wrong state shows on the bus in the same clock. A state that skips or repeats a step produces a command out of order, or a NOP run of the wrong length, in the cycle where it happens. A fault in the gap timer or the refresh counter shifts every later command and the rise of `done_o`, so it shows within one refresh period. The bench compares a cycle-exact expected trace for both orderings of the refresh burst, and catches an error on the first cycle that differs.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PAUSE,
    ST_PRE,
    ST_WAIT_RP,
    ST_MRS,
    ST_WAIT_MRD,
    ST_REF,
    ST_WAIT_RC,
    ST_DONE
  } state_e;

  // address bit that selects all banks on a precharge
  localparam int unsigned PRE_ALL_BIT = 10;
  localparam int unsigned MODE_W      = 7;

  typedef struct packed {
    logic [2:0] cl;
    logic       wrap;
    logic [2:0] bl;
  } mode_t;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_mode_word.sv
module sdram_init_mode_word
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [2:0]        bl_i,
  input  logic              wrap_i,
  input  logic [2:0]        cl_i,
  output logic [ADDR_W-1:0] word_o
);

  mode_t fields;

  always_comb begin
    fields.bl   = bl_i;
    fields.wrap = wrap_i;
    fields.cl   = cl_i;
  end

  generate
    if (ADDR_W > MODE_W) begin : g_pad
      assign word_o = {{(ADDR_W - MODE_W){1'b0}}, fields};
    end else begin : g_trim
      assign word_o = fields[ADDR_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned DQM_W  = 2
) (
  input  state_e            st_i,
  input  logic [ADDR_W-1:0] mode_word_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cke_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              done_o
);

  cmd_e cmd;

  always_comb begin
    cmd    = CMD_NOP;
    addr_o = '0;
    cke_o  = 1'b1;
    dqm_o  = '1;
    done_o = 1'b0;
    unique case (st_i)
      ST_IDLE: cmd = CMD_DESEL;
      ST_PRE: begin
        cmd                 = CMD_PRE;
        addr_o[PRE_ALL_BIT] = 1'b1;
      end
      ST_MRS: begin
        cmd    = CMD_MRS;
        addr_o = mode_word_i;
      end
      ST_REF: cmd = CMD_REF;
      ST_DONE: begin
        dqm_o  = '0;
        done_o = 1'b1;
      end
      default: cmd = CMD_NOP;
    endcase
  end

  // mode load needs both bank bits low; nothing else here uses them
  assign ba_o = '0;
  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 20_000_000, // 200 ms at 100 MHz
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RC      = 8,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned N_REF     = 8,
  parameter bit          REF_FIRST = 1'b0,
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned DQM_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        bl_i,
  input  logic              wrap_i,
  input  logic [2:0]        cl_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cke_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              done_o
);

  localparam int unsigned MAXV = max2(max2(PAUSE_CYC, T_RC), max2(T_RP, T_MRD));
  localparam int unsigned TW   = $clog2(MAXV + 1);
  localparam int unsigned RW   = $clog2(N_REF + 1);

  localparam logic [TW-1:0] PAUSE_LD = TW'(PAUSE_CYC - 1);
  localparam logic [TW-1:0] RP_LD    = TW'(T_RP - 2);
  localparam logic [TW-1:0] RC_LD    = TW'(T_RC - 2);
  localparam logic [TW-1:0] MRD_LD   = TW'(T_MRD - 2);
  localparam logic [RW-1:0] REF_LAST = RW'(N_REF);

  initial begin
    if (PAUSE_CYC < 1 || T_RP < 2 || T_RC < 2 || T_MRD < 2 || N_REF < 1)
      $error("sdram_init_seq: timing parameters out of range");
    if (ADDR_W <= PRE_ALL_BIT)
      $error("sdram_init_seq: address bus too narrow");
  end

  state_e         st_q, st_d;
  logic           ld;
  logic [TW-1:0]  ld_val;
  logic           tmr_zero;
  logic [RW-1:0]  ref_q;
  logic           ref_inc, ref_clr;
  logic [ADDR_W-1:0] mode_word;

  // order-dependent successors
  state_e after_rp, after_mrd, after_refs;
  assign after_rp   = REF_FIRST ? ST_REF  : ST_MRS;
  assign after_mrd  = REF_FIRST ? ST_DONE : ST_REF;
  assign after_refs = REF_FIRST ? ST_MRS  : ST_DONE;

  always_comb begin
    st_d    = st_q;
    ld      = 1'b0;
    ld_val  = '0;
    ref_inc = 1'b0;
    ref_clr = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        st_d    = ST_PAUSE;
        ld      = 1'b1;
        ld_val  = PAUSE_LD;
        ref_clr = 1'b1;
      end
      ST_PAUSE:    if (tmr_zero) st_d = ST_PRE;
      ST_PRE: begin
        st_d   = ST_WAIT_RP;
        ld     = 1'b1;
        ld_val = RP_LD;
      end
      ST_WAIT_RP:  if (tmr_zero) st_d = after_rp;
      ST_MRS: begin
        st_d   = ST_WAIT_MRD;
        ld     = 1'b1;
        ld_val = MRD_LD;
      end
      ST_WAIT_MRD: if (tmr_zero) st_d = after_mrd;
      ST_REF: begin
        st_d    = ST_WAIT_RC;
        ld      = 1'b1;
        ld_val  = RC_LD;
        ref_inc = 1'b1;
      end
      ST_WAIT_RC:
        if (tmr_zero) st_d = (ref_q == REF_LAST) ? after_refs : ST_REF;
      ST_DONE:     st_d = ST_DONE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ref_q <= '0;
    else if (ref_clr) ref_q <= '0;
    else if (ref_inc) ref_q <= ref_q + 1'b1;
  end

  sdram_init_timer #(.W(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_val_i (ld_val),
    .zero_o     (tmr_zero)
  );

  sdram_init_mode_word #(.ADDR_W(ADDR_W)) u_mode (
    .bl_i   (bl_i),
    .wrap_i (wrap_i),
    .cl_i   (cl_i),
    .word_o (mode_word)
  );

  sdram_init_cmd_enc #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .DQM_W  (DQM_W)
  ) u_enc (
    .st_i        (st_q),
    .mode_word_i (mode_word),
    .cs_n_o      (cs_n_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .we_n_o      (we_n_o),
    .ba_o        (ba_o),
    .addr_o      (addr_o),
    .cke_o       (cke_o),
    .dqm_o       (dqm_o),
    .done_o      (done_o)
  );

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk
  import sdram_init_pkg::*;
#(
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_RC   = 8,
  parameter int unsigned N_REF  = 8,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned DQM_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [BA_W-1:0]   ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              cke_o,
  input logic [DQM_W-1:0]  dqm_o,
  input logic              done_o
);

  logic [3:0] cmd;
  logic       act;
  logic       seen_pre, seen_mrs, last_pre, last_ref;
  int unsigned gap, nref;

  assign cmd = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign act = !cs_n_o && (cmd != CMD_NOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_pre <= 1'b0;
      seen_mrs <= 1'b0;
      last_pre <= 1'b0;
      last_ref <= 1'b0;
      gap      <= 0;
      nref     <= 0;
    end else begin
      if (act) begin
        gap      <= 1;
        last_pre <= (cmd == CMD_PRE);
        last_ref <= (cmd == CMD_REF);
      end else if (gap < 1000) begin
        gap <= gap + 1;
      end
      if (cmd == CMD_PRE) seen_pre <= 1'b1;
      if (cmd == CMD_MRS) seen_mrs <= 1'b1;
      if (cmd == CMD_REF && nref < N_REF) nref <= nref + 1;
    end
  end

  AST_PAUSE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_pre && cmd != CMD_PRE |-> (cmd == CMD_NOP || cs_n_o) && cke_o && (&dqm_o)); // R2

  AST_FIRST_PRE_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && !seen_pre |-> cmd == CMD_PRE && addr_o[PRE_ALL_BIT]); // R3

  AST_TRP_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && last_pre |-> gap >= T_RP); // R4

  AST_MRS_BA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_MRS |-> ba_o == '0); // R5

  AST_MRS_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_MRS |-> (addr_o >> MODE_W) == '0); // R5

  AST_MRS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_MRS |-> seen_pre && $past(cke_o)); // R6

  AST_MRS_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_MRS |=> cmd == CMD_NOP); // R7

  AST_TRC_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && last_ref |-> gap >= T_RC); // R8

  AST_DONE_AFTER_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> seen_mrs && nref >= N_REF); // R9

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o); // R9

  AST_DONE_IDLE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd == CMD_NOP && dqm_o == '0 && cke_o); // R9

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .T_RP   (T_RP),
  .T_RC   (T_RC),
  .N_REF  (N_REF),
  .ADDR_W (ADDR_W),
  .BA_W   (BA_W),
  .DQM_W  (DQM_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_n_o  (cs_n_o),
  .ras_n_o (ras_n_o),
  .cas_n_o (cas_n_o),
  .we_n_o  (we_n_o),
  .ba_o    (ba_o),
  .addr_o  (addr_o),
  .cke_o   (cke_o),
  .dqm_o   (dqm_o),
  .done_o  (done_o)
);

// File: tb/sdram_init_seq_test.sv
`timescale 1ns/1ps
module sdram_init_seq_test;

  localparam int PAUSE = 40;
  localparam int TRP   = 3;
  localparam int TRC   = 6;
  localparam int TMRD  = 2;
  localparam int NREF  = 8;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic        cke;
    logic [1:0]  dqm;
    logic        done;
  } obs_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic [2:0] bl = 3'b011;
  logic       wrap = 1'b0;
  logic [2:0] cl = 3'b010;

  logic cs0, ras0, cas0, we0, cke0, done0;
  logic cs1, ras1, cas1, we1, cke1, done1;
  logic [1:0] ba0, ba1, dqm0, dqm1;
  logic [12:0] addr0, addr1;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit mon_on  = 1'b0;
  string rst_tag = "R1";

  obs_t  q0[$], q1[$];
  string t0[$], t1[$];

  always #2 clk = ~clk;

  sdram_init_seq #(.PAUSE_CYC(PAUSE), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD),
                   .N_REF(NREF), .REF_FIRST(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .bl_i(bl), .wrap_i(wrap), .cl_i(cl),
    .cs_n_o(cs0), .ras_n_o(ras0), .cas_n_o(cas0), .we_n_o(we0),
    .ba_o(ba0), .addr_o(addr0), .cke_o(cke0), .dqm_o(dqm0), .done_o(done0));

  sdram_init_seq #(.PAUSE_CYC(PAUSE), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD),
                   .N_REF(NREF), .REF_FIRST(1'b1)) uut_rf (
    .clk_i(clk), .rst_ni(rst_ni), .bl_i(bl), .wrap_i(wrap), .cl_i(cl),
    .cs_n_o(cs1), .ras_n_o(ras1), .cas_n_o(cas1), .we_n_o(we1),
    .ba_o(ba1), .addr_o(addr1), .cke_o(cke1), .dqm_o(dqm1), .done_o(done1));

  function automatic obs_t mk(logic [3:0] c, logic [12:0] a, logic m, logic d);
    obs_t o;
    o.cmd  = c;
    o.ba   = 2'b00;
    o.addr = a;
    o.cke  = 1'b1;
    o.dqm  = {2{m}};
    o.done = d;
    return o;
  endfunction

  task automatic check(obs_t act, obs_t exp, string tag, string who);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s cyc %0d: got %h exp %h", tag, who, cyc, act, exp);
    end
  endtask

  task automatic push(bit rf, obs_t o, string tag);
    if (rf) begin q1.push_back(o); t1.push_back(tag); end
    else    begin q0.push_back(o); t0.push_back(tag); end
  endtask

  // driver: expected per-cycle bus trace of one full run
  task automatic plan_run(bit rf, string pfx);
    obs_t nop;
    nop = mk(4'b0111, 13'd0, 1'b1, 1'b0);
    push(rf, mk(4'b1111, 13'd0, 1'b1, 1'b0), {pfx, "R2"});
    for (int i = 0; i < PAUSE; i++) push(rf, nop, {pfx, "R2"});
    push(rf, mk(4'b0010, 13'h0400, 1'b1, 1'b0), {pfx, "R3"});
    for (int i = 0; i < TRP - 1; i++) push(rf, nop, {pfx, "R4"});
    if (!rf) begin
      push(rf, mk(4'b0000, {6'd0, cl, wrap, bl}, 1'b1, 1'b0), {pfx, "R5 R6"});
      for (int i = 0; i < TMRD - 1; i++) push(rf, nop, {pfx, "R7"});
    end
    for (int k = 0; k < NREF; k++) begin
      push(rf, mk(4'b0001, 13'd0, 1'b1, 1'b0), {pfx, "R8"});
      for (int i = 0; i < TRC - 1; i++) push(rf, nop, {pfx, "R8"});
    end
    if (rf) begin
      push(rf, mk(4'b0000, {6'd0, cl, wrap, bl}, 1'b1, 1'b0), {pfx, "R5 R6"});
      for (int i = 0; i < TMRD - 1; i++) push(rf, nop, {pfx, "R7"});
    end
    for (int i = 0; i < 4; i++) push(rf, mk(4'b0111, 13'd0, 1'b0, 1'b1), {pfx, "R9"});
  endtask

  task automatic flush();
    q0.delete(); q1.delete(); t0.delete(); t1.delete();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    obs_t a0, a1, e;
    a0 = '{cmd: {cs0, ras0, cas0, we0}, ba: ba0, addr: addr0, cke: cke0, dqm: dqm0, done: done0};
    a1 = '{cmd: {cs1, ras1, cas1, we1}, ba: ba1, addr: addr1, cke: cke1, dqm: dqm1, done: done1};
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got cyc %0d exp < 20000", cyc);
      summary();
    end
    if (mon_on) begin
      if (!rst_ni) begin
        e = mk(4'b1111, 13'd0, 1'b1, 1'b0);
        check(a0, e, rst_tag, "uut");
        check(a1, e, rst_tag, "uut_rf");
      end else begin
        if (q0.size() > 0) check(a0, q0.pop_front(), t0.pop_front(), "uut");
        if (q1.size() > 0) check(a1, q1.pop_front(), t1.pop_front(), "uut_rf");
      end
    end
  end

  task automatic wait_empty();
    while (q0.size() > 0 || q1.size() > 0) @(posedge clk);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    mon_on = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // run 1: both orders, mode A
    plan_run(1'b0, "");
    plan_run(1'b1, "");
    rst_ni = 1'b1;
    wait_empty();
    repeat (5) @(posedge clk);
    // R5 second mode pattern, R1 reset from done
    #1;
    bl = 3'b010; wrap = 1'b1; cl = 3'b011;
    rst_ni = 1'b0;
    rst_tag = "R1 R10";
    flush();
    repeat (2) @(posedge clk);
    #1;
    plan_run(1'b0, "");
    plan_run(1'b1, "");
    rst_ni = 1'b1;
    repeat (PAUSE + 10) @(posedge clk);
    // R10 reset part-way, after precharge, with new mode inputs
    #1;
    rst_ni = 1'b0;
    flush();
    bl = 3'b111; wrap = 1'b0; cl = 3'b101;
    repeat (2) @(posedge clk);
    #1;
    plan_run(1'b0, "R10 ");
    plan_run(1'b1, "R10 ");
    rst_ni = 1'b1;
    wait_empty();
    repeat (3) @(posedge clk);
    summary();
  end

endmodule